// File: doc/BRIEF.md
# Drive Protection Supervisor

This block watches over a brushless motor drive while it runs and decides when the high-side drive and the PWM chopping must be switched off. It works entirely in the system clock domain. The run/stop request, the brake request, the speed-lock flag, the external speed reference clock and an undervoltage flag are all brought in through synchronisers. Three registered status lines come out: a high-side disable, a PWM disable and a latched fault.

The main protection is a rotor-stall guard. While the drive is running and the speed loop reports no lock, a timer counts up to a programmable limit, normally a few seconds. When the limit is reached, a fault latches and shuts the drive off. Only two things clear the fault: a stop or brake request held without a break for a programmable time (nominally about 1 ms), or a reset. A second, non-latching guard blanks the PWM while the speed reference clock has stopped toggling, and releases it as soon as edges return. An undervoltage flag, which carries its hysteresis from the analog side, forces both disables for as long as it is set. A reset forces the drive off.

Top module: `drive_prot_sup`

## Requirements
- R1: During reset, and while stop is still requested after reset, hs_off=1, pwm_off=1 and fault=0.
- R2: In run mode (stop_req=0, brake_req=0), with speed_locked=1, uv_flag=0 and rising edges on ext_clk more often than every LOSS_CYCLES clocks, hs_off=0 and pwm_off=0.
- R3: With stop_req=1, hs_off=1 and pwm_off=1, and the stall timer is held at zero. After any length of stop, a fault needs a full PROT_CYCLES of unlocked run.
- R4: In run mode with uv_flag=0 and speed_locked=0 held for PROT_CYCLES consecutive clocks, fault becomes 1 and both hs_off and pwm_off become 1.
- R5: Any clock in run mode with speed_locked=1 returns the stall timer to zero.
- R6: Once set, fault stays 1 when lock and the speed clock return while run is requested.
- R7: fault clears only after stop_req=1 or brake_req=1 has been held for CLR_CYCLES consecutive clocks. A return to run before then restarts the count.
- R8: In run mode, when LOSS_CYCLES clocks pass with no rising edge on ext_clk, pwm_off=1 while hs_off is unaffected. The next rising edge releases the blanking without any clearing step.
- R9: With brake_req=1 and stop_req=0 (no fault, no undervoltage), hs_off=0 and pwm_off=0. Clock loss has no effect, and the stall timer is held at zero.
- R10: While uv_flag=1, hs_off=1 and pwm_off=1, no stall time accumulates, and the outputs return when uv_flag=0.
- R11: Reset clears a latched fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| stop_req | input | 1 | 1 = stop requested, 0 = run |
| brake_req | input | 1 | 1 = short-brake requested |
| speed_locked | input | 1 | 1 = speed loop within lock range |
| ext_clk | input | 1 | External speed reference clock (asynchronous) |
| uv_flag | input | 1 | 1 = supply undervoltage (hysteresis applied outside) |
| hs_off | output | 1 | 1 = high-side drive disabled |
| pwm_off | output | 1 | 1 = PWM chopping blanked |
| fault | output | 1 | 1 = latched rotor-stall fault |

## Verification
The stall timer and the clock-loss blanking can act at the same moment, because a vanished speed clock also leaves the speed loop unlocked. The bench provokes this by stopping the reference clock and dropping lock together in run mode. It checks that pwm_off goes high first while hs_off stays low, and that the stall limit later raises hs_off and fault. Once the fault has latched, bringing the clock and lock back must not restore the drive: the non-latching blanking has been overtaken by the latched fault.

// File: rtl/drvprot_pkg.sv
package drvprot_pkg;

    typedef struct packed {
        logic stop;
        logic brake;
        logic locked;
        logic uv;
        logic extclk;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    localparam ctl_t CTL_RST = '{stop: 1'b1, brake: 1'b0, locked: 1'b0,
                                 uv: 1'b0, extclk: 1'b0};

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_BRAKE = 2'd1,
        MODE_STOP  = 2'd2
    } drive_mode_e;

    // stop dominates brake
    function automatic drive_mode_e decode_mode(input logic stop, input logic brake);
        if (stop)
            return MODE_STOP;
        else if (brake)
            return MODE_BRAKE;
        else
            return MODE_RUN;
    endfunction

    function automatic int cnt_bits(input longint limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/drvprot_sync.sv
module drvprot_sync #(
    parameter int               WIDTH   = 5,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] pipe [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[g] <= RST_VAL;
                else     pipe[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) pipe[g] <= RST_VAL;
                else     pipe[g] <= pipe[g-1];
            end
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/drvprot_clkwatch.sv
module drvprot_clkwatch #(
    parameter int LOSS_CYCLES = 25000
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_s,
    output logic lost
);
    import drvprot_pkg::*;

    localparam int W = cnt_bits(LOSS_CYCLES);
    localparam logic [W-1:0] LIM = W'(LOSS_CYCLES);

    logic         ref_prev;
    logic         edge_s;
    logic [W-1:0] gap_cnt;

    assign edge_s = ref_s & ~ref_prev;
    assign lost   = (gap_cnt == LIM);

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_prev <= 1'b0;
            gap_cnt  <= '0;
        end else begin
            ref_prev <= ref_s;
            if (edge_s)
                gap_cnt <= '0;
            else if (gap_cnt != LIM)
                gap_cnt <= gap_cnt + 1'b1;
        end
    end

    AST_EDGE_RELEASES: assert property (@(posedge clk) disable iff (rst)
        edge_s |=> !lost); // R8
    AST_LOSS_STICKY: assert property (@(posedge clk) disable iff (rst)
        (lost && !edge_s) |=> lost); // R8

endmodule

// File: rtl/drvprot_stallguard.sv
module drvprot_stallguard #(
    parameter longint PROT_CYCLES = 150000000,
    parameter int     CLR_CYCLES  = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic hold,
    input  logic locked,
    output logic fault
);
    import drvprot_pkg::*;

    localparam int TW = cnt_bits(PROT_CYCLES);
    localparam int HW = cnt_bits(CLR_CYCLES);
    localparam logic [TW-1:0] T_LIM = TW'(PROT_CYCLES - 1);
    localparam logic [HW-1:0] H_LIM = HW'(CLR_CYCLES - 1);

    logic [TW-1:0] stall_tmr;
    logic [HW-1:0] hold_cnt;
    logic          fault_q;

    assign fault = fault_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stall_tmr <= '0;
            hold_cnt  <= '0;
            fault_q   <= 1'b0;
        end else begin
            // stall timer: counts unlocked run clocks
            if (!run || locked)
                stall_tmr <= '0;
            else if (!fault_q) begin
                if (stall_tmr == T_LIM)
                    fault_q <= 1'b1;
                else
                    stall_tmr <= stall_tmr + 1'b1;
            end

            // clear-hold counter: must see stop/brake without a break
            if (hold) begin
                if (hold_cnt == H_LIM) begin
                    if (fault_q)
                        fault_q <= 1'b0;
                end else begin
                    hold_cnt <= hold_cnt + 1'b1;
                end
            end else begin
                hold_cnt <= '0;
            end
        end
    end

    AST_FAULT_FROM_STALL: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_q) |-> $past(run && !locked)); // R4
    AST_FAULT_CLEAR_NEEDS_HOLD: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_q) |-> $past(hold)); // R7
    AST_TIMER_IDLE: assert property (@(posedge clk) disable iff (rst)
        !run |=> (stall_tmr == '0)); // R3
    AST_LOCK_RESETS_TIMER: assert property (@(posedge clk) disable iff (rst)
        (run && locked) |=> (stall_tmr == '0)); // R5

endmodule

// File: rtl/drive_prot_sup.sv
module drive_prot_sup #(
    parameter longint PROT_CYCLES = 150000000,
    parameter int     CLR_CYCLES  = 50000,
    parameter int     LOSS_CYCLES = 25000,
    parameter int     SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic stop_req,
    input  logic brake_req,
    input  logic speed_locked,
    input  logic ext_clk,
    input  logic uv_flag,
    output logic hs_off,
    output logic pwm_off,
    output logic fault
);
    import drvprot_pkg::*;

    ctl_t        ctl_raw;
    ctl_t        ctl_s;
    drive_mode_e mode;
    logic        run_ok;
    logic        hold;
    logic        clk_lost;
    logic        fault_q;
    logic        off_all;
    logic        hs_off_q;
    logic        pwm_off_q;

    assign ctl_raw.stop   = stop_req;
    assign ctl_raw.brake  = brake_req;
    assign ctl_raw.locked = speed_locked;
    assign ctl_raw.uv     = uv_flag;
    assign ctl_raw.extclk = ext_clk;

    drvprot_sync #(
        .WIDTH  (CTL_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(CTL_RST)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (ctl_raw),
        .q  (ctl_s)
    );

    assign mode   = decode_mode(ctl_s.stop, ctl_s.brake);
    assign run_ok = (mode == MODE_RUN) && !ctl_s.uv;
    assign hold   = (mode != MODE_RUN);

    drvprot_clkwatch #(
        .LOSS_CYCLES(LOSS_CYCLES)
    ) u_clkwatch (
        .clk  (clk),
        .rst  (rst),
        .ref_s(ctl_s.extclk),
        .lost (clk_lost)
    );

    drvprot_stallguard #(
        .PROT_CYCLES(PROT_CYCLES),
        .CLR_CYCLES (CLR_CYCLES)
    ) u_stall (
        .clk   (clk),
        .rst   (rst),
        .run   (run_ok),
        .hold  (hold),
        .locked(ctl_s.locked),
        .fault (fault_q)
    );

    assign off_all = ctl_s.uv || fault_q || (mode == MODE_STOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_off_q  <= 1'b1;
            pwm_off_q <= 1'b1;
        end else begin
            hs_off_q  <= off_all;
            pwm_off_q <= off_all || ((mode == MODE_RUN) && clk_lost);
        end
    end

    assign hs_off  = hs_off_q;
    assign pwm_off = pwm_off_q;
    assign fault   = fault_q;

    AST_UV_BLANKS: assert property (@(posedge clk) disable iff (rst)
        ctl_s.uv |=> (hs_off_q && pwm_off_q)); // R10
    AST_STOP_BLANKS: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_STOP) |=> (hs_off_q && pwm_off_q)); // R3
    AST_FAULT_DISABLES: assert property (@(posedge clk) disable iff (rst)
        fault_q |=> (hs_off_q && pwm_off_q)); // R4
    AST_BRAKE_DRIVES: assert property (@(posedge clk) disable iff (rst)
        ((mode == MODE_BRAKE) && !fault_q && !ctl_s.uv) |=> (!hs_off_q && !pwm_off_q)); // R9
    AST_HS_IMPLIES_PWM: assert property (@(posedge clk) disable iff (rst)
        hs_off_q |-> pwm_off_q); // R8

endmodule

// File: tb/drive_prot_sup_test.sv
module drive_prot_sup_test;

    localparam int PROT = 200;
    localparam int CLR  = 40;
    localparam int LOSS = 30;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stop_req = 1'b1;
    logic brake_req = 1'b0;
    logic speed_locked = 1'b0;
    logic ext_clk = 1'b0;
    logic uv_flag = 1'b0;
    logic ext_en = 1'b0;
    logic hs_off, pwm_off, fault;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [2:0] exp_q [$];
    string      tag_q [$];

    always #10 clk = ~clk;

    drive_prot_sup #(
        .PROT_CYCLES(PROT),
        .CLR_CYCLES (CLR),
        .LOSS_CYCLES(LOSS)
    ) uut (
        .clk(clk), .rst(rst), .stop_req(stop_req), .brake_req(brake_req),
        .speed_locked(speed_locked), .ext_clk(ext_clk), .uv_flag(uv_flag),
        .hs_off(hs_off), .pwm_off(pwm_off), .fault(fault)
    );

    // speed reference clock: rising edge every 8 system clocks when enabled
    initial begin
        forever begin
            repeat (4) @(posedge clk);
            #1;
            if (ext_en) ext_clk = ~ext_clk;
        end
    end

    // monitor: pops expected items and compares with outputs
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [2:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if ({hs_off, pwm_off, fault} !== e) begin
                n_bad++;
                $display("FAIL %s: hs_off/pwm_off/fault got %b%b%b expected %b",
                         t, hs_off, pwm_off, fault, e);
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input logic h, input logic p, input logic f, input string t);
        exp_q.push_back({h, p, f});
        tag_q.push_back(t);
        @(negedge clk);
        #1;
    endtask

    task automatic drive(input logic s, input logic b, input logic l, input logic u);
        @(posedge clk);
        #1;
        stop_req = s; brake_req = b; speed_locked = l; uv_flag = u;
    endtask

    initial begin
        // R1: reset state
        wait_cyc(3);
        expect_out(1, 1, 0, "R1 in reset");
        wait_cyc(2);
        rst = 1'b0;
        wait_cyc(6);
        expect_out(1, 1, 0, "R1 stop after reset");

        // R2: normal run
        ext_en = 1'b1;
        drive(0, 0, 1, 0);
        wait_cyc(10);
        expect_out(0, 0, 0, "R2 run locked");

        // R3: stop blanks and holds the stall timer
        drive(1, 0, 0, 0);
        wait_cyc(8);
        expect_out(1, 1, 0, "R3 stop blanks");
        wait_cyc(PROT + 20);
        expect_out(1, 1, 0, "R3 no fault while stopped");
        drive(0, 0, 0, 0);
        wait_cyc(PROT - 3);
        expect_out(0, 0, 0, "R3 timer restarted from zero");

        // R4: stall fault
        wait_cyc(10);
        expect_out(1, 1, 1, "R4 stall fault latched");

        // R6: fault persists with lock back
        drive(0, 0, 1, 0);
        wait_cyc(12);
        expect_out(1, 1, 1, "R6 fault holds with lock");

        // R7: interrupted hold restarts the count
        drive(1, 0, 1, 0);
        wait_cyc(CLR - 12);
        expect_out(1, 1, 1, "R7 partial hold 1");
        drive(0, 0, 1, 0);
        wait_cyc(6);
        drive(1, 0, 1, 0);
        wait_cyc(CLR - 12);
        expect_out(1, 1, 1, "R7 partial hold 2 no clear");
        wait_cyc(20);
        expect_out(1, 1, 0, "R7 full hold clears");

        // R5: relock resets the timer
        drive(0, 0, 0, 0);
        wait_cyc(PROT / 2);
        drive(0, 0, 1, 0);
        wait_cyc(6);
        drive(0, 0, 0, 0);
        wait_cyc(PROT - 4);
        expect_out(0, 0, 0, "R5 relock restarted timer");
        drive(0, 0, 1, 0);
        wait_cyc(8);
        expect_out(0, 0, 0, "R2 run again");

        // R8: clock loss blanks PWM only, recovers on its own
        ext_en = 1'b0;
        wait_cyc(LOSS + 20);
        expect_out(0, 1, 0, "R8 clock loss blanks pwm");
        ext_en = 1'b1;
        wait_cyc(18);
        expect_out(0, 0, 0, "R8 clock return releases");

        // R9: brake
        drive(0, 1, 1, 0);
        wait_cyc(8);
        expect_out(0, 0, 0, "R9 brake drives");
        ext_en = 1'b0;
        drive(0, 1, 0, 0);
        wait_cyc(PROT + 20);
        expect_out(0, 0, 0, "R9 brake ignores loss and stall");
        ext_en = 1'b1;
        drive(0, 0, 1, 0);
        wait_cyc(18);
        expect_out(0, 0, 0, "R9 back to run");

        // R10: undervoltage
        drive(0, 0, 1, 1);
        wait_cyc(6);
        expect_out(1, 1, 0, "R10 uv blanks");
        drive(0, 0, 0, 1);
        wait_cyc(PROT + 20);
        expect_out(1, 1, 0, "R10 no stall time under uv");
        drive(0, 0, 1, 0);
        wait_cyc(8);
        expect_out(0, 0, 0, "R10 uv released");

        // clock loss and stall timer active together
        ext_en = 1'b0;
        drive(0, 0, 0, 0);
        wait_cyc(LOSS + 20);
        expect_out(0, 1, 0, "R8 loss before stall expiry");
        wait_cyc(PROT - LOSS);
        expect_out(1, 1, 1, "R4 stall overtakes loss");
        ext_en = 1'b1;
        drive(0, 0, 1, 0);
        wait_cyc(20);
        expect_out(1, 1, 1, "R6 latched after clock return");

        // R7: brake hold also clears
        drive(0, 1, 1, 0);
        wait_cyc(CLR + 10);
        expect_out(0, 0, 0, "R7 brake hold clears");

        // R11: reset clears a fault
        drive(0, 0, 0, 0);
        wait_cyc(PROT + 8);
        expect_out(1, 1, 1, "R4 fault again");
        rst = 1'b1;
        drive(0, 0, 1, 0);
        wait_cyc(3);
        expect_out(1, 1, 0, "R11 reset clears fault");
        rst = 1'b0;
        wait_cyc(10);
        expect_out(0, 0, 0, "R11 runs after reset");

        wait_cyc(3);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule